// File: doc/BRIEF.md
# Hypervisor Debug Trap Control Register

This block holds the hypervisor-level debug configuration word and, from it, decides whether a request from a less privileged, non-secure context has to be redirected to the hypervisor. The word is reached through a system-register port. Only the hypervisor level, or the monitor level while its non-secure flag is set, may read or write it. Any other level that tries gets an undefined-access flag, and the stored word stays as it was.

A second, independent port carries an access or event that has already been classified. It gives the exception level, the security state, a category code and a global guest-trap flag. The block answers with a combinational trap signal in the same cycle. The debug-exception trap bit and the guest-trap flag each force the three debug register trap enables on, whatever the stored bits hold. Reads always return the stored bits, never the forced ones.

Top module: `hyp_dbg_trap_ctrl`

## Requirements
- R1: After reset the stored word is 0x0000_0006: bits 11 to 5 are zero and the counter partition field in bits 4:0 holds 6.
- R2: A read (`sr_rd_en`) from EL2 (`sr_el`=2), or from EL3 (`sr_el`=3) with `sr_ns`=1, returns the stored word on `sr_rdata` in the same cycle. From any other level, `sr_rdata` is zero.
- R3: A write from a permitted level updates the word at the next rising edge. Bits 31:12 always read as zero, whatever was written.
- R4: A read or write attempt from EL0, EL1 or EL3 with `sr_ns`=0 sets `sr_undef` for exactly the following cycle. Such a write leaves the stored word unchanged.
- R5: For a valid non-secure request from EL0 or EL1, `trap` is combinational and is driven by these stored bits:
  - category 0 (debug ROM address registers): bit 11
  - category 1 (OS-related debug registers): bit 10
  - category 2 (other debug registers): bit 9
  - category 3 (performance monitor registers): bit 6
  - category 4 (performance monitor control register): bit 5
- R6: `trap` stays low when `req_valid` is 0, when `req_ns` is 0, or for categories 0 to 4 requested from EL2 or EL3.
- R7: With bit 8 set, categories 0, 1 and 2 trap whatever bits 11:9 hold. Bit 8 does not force categories 3 or 4.
- R8: With `guest_trap` high, the block behaves as if bit 8 were set. Categories 0, 1, 2 and 5 then trap, whatever is stored.
- R9: Category 5 (debug exception) traps when it is non-secure and bit 8 is effectively set, at any exception level.
- R10: Reads return the stored bits, not the forced values. Bit 7 and bits 4:0 are stored and read back, but they have no effect on `trap`.
- R11: Category codes 6 and 7 never trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_wr_en | input | 1 | System-register write strobe |
| sr_rd_en | input | 1 | System-register read strobe |
| sr_el | input | 2 | Exception level of the register access |
| sr_ns | input | 1 | Non-secure flag of the register access |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data, combinational |
| sr_undef | output | 1 | Undefined-access pulse, one cycle after a refused attempt |
| req_valid | input | 1 | Classified request is present |
| req_el | input | 2 | Exception level of the request |
| req_ns | input | 1 | Request is non-secure |
| req_cat | input | 3 | Request category code (0 to 7) |
| guest_trap | input | 1 | Global guest-trap flag |
| trap | output | 1 | Request must be trapped to the hypervisor |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 12 implemented bits and a reset partition value of 6. These values make every reserved bit reachable by the write-masking checks. A reference model follows the stored word cycle by cycle. It compares read data, the undefined pulse and the trap decision against it, over directed sequences and then thousands of random cycles. The random stimulus covers all four levels, both security states, all eight categories and the guest flag. Each forcing interaction therefore meets each stored-bit combination many times.

// File: rtl/hdt_pkg.sv
// Package: shared encodings for the hypervisor debug trap control block.
// Assumes: request categories fit in 3 bits and exception levels in 2 bits.
package hdt_pkg;
    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } hdt_level_e;

    typedef enum logic [2:0] {
        CAT_ROM  = 3'd0,
        CAT_OS   = 3'd1,
        CAT_DBG  = 3'd2,
        CAT_PM   = 3'd3,
        CAT_PMC  = 3'd4,
        CAT_EXC  = 3'd5,
        CAT_NA6  = 3'd6,
        CAT_NA7  = 3'd7
    } hdt_cat_e;

    localparam int CAT_W        = 3;
    localparam int NUM_CAT      = 1 << CAT_W;

    localparam int BIT_TRAP_ROM = 11;
    localparam int BIT_TRAP_OS  = 10;
    localparam int BIT_TRAP_DBG = 9;
    localparam int BIT_TRAP_EXC = 8;
    localparam int BIT_HPC_EN   = 7;
    localparam int BIT_TRAP_PM  = 6;
    localparam int BIT_TRAP_PMC = 5;
    localparam int PMN_LSB      = 0;
endpackage

// File: rtl/hdt_access_gate.sv
// Module: decides whether a system-register access is permitted and
// produces the registered one-cycle undefined-access pulse.
// Assumes: EL2 is always permitted; EL3 only when its non-secure flag is set.
module hdt_access_gate
    import hdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] lvl,
    input  logic       ns,
    output logic       wr_ok,
    output logic       rd_ok,
    output logic       undef_q
);
    logic permitted;
    logic refused;

    // Level check for the register port.
    always_comb begin
        permitted = (lvl == LVL_2) || ((lvl == LVL_3) && ns);
        wr_ok     = wr_en && permitted;
        rd_ok     = rd_en && permitted;
        refused   = (wr_en || rd_en) && !permitted;
    end

    // One-cycle pulse after a refused attempt.
    always_ff @(posedge clk) begin
        if (!rst_n) undef_q <= 1'b0;
        else        undef_q <= refused;
    end
endmodule

// File: rtl/hdt_cfg_reg.sv
// Module: storage for the configuration word. Only the low IMPL_W bits
// hold state; the bits above are constant zero and drop writes.
// Assumes: RST_VAL bits at or above IMPL_W are zero.
module hdt_cfg_reg #(
    parameter int          DATA_W  = 32,
    parameter int          IMPL_W  = 12,
    parameter logic [31:0] RST_VAL = 32'h6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ok,
    input  logic [IMPL_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    genvar g;
    generate
        for (g = 0; g < DATA_W; g++) begin : g_bit
            if (g < IMPL_W) begin : g_impl
                // Implemented bit: loads on a permitted write.
                always_ff @(posedge clk) begin
                    if (!rst_n)     cfg_q[g] <= RST_VAL[g];
                    else if (wr_ok) cfg_q[g] <= wdata[g];
                end
            end else begin : g_rsvd
                assign cfg_q[g] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/hdt_trap_eval.sv
// Module: combinational trap decision from the stored word, the guest
// flag and a classified request.
// Assumes: category codes follow hdt_cat_e; unused codes never trap.
module hdt_trap_eval
    import hdt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] cfg,
    input  logic              guest_trap,
    input  logic              req_valid,
    input  logic [1:0]        req_lvl,
    input  logic              req_ns,
    input  logic [CAT_W-1:0]  req_cat,
    output logic              trap
);
    logic               exc_eff;
    logic [NUM_CAT-1:0] cat_en;
    logic               lower_lvl;
    logic               is_exc;

    // Effective debug-exception trap, forced by the guest flag.
    assign exc_eff = cfg[BIT_TRAP_EXC] | guest_trap;

    genvar c;
    generate
        for (c = 0; c < NUM_CAT; c++) begin : g_cat
            if (c == int'(CAT_ROM)) begin : g_rom
                assign cat_en[c] = cfg[BIT_TRAP_ROM] | exc_eff;
            end else if (c == int'(CAT_OS)) begin : g_os
                assign cat_en[c] = cfg[BIT_TRAP_OS] | exc_eff;
            end else if (c == int'(CAT_DBG)) begin : g_dbg
                assign cat_en[c] = cfg[BIT_TRAP_DBG] | exc_eff;
            end else if (c == int'(CAT_PM)) begin : g_pm
                assign cat_en[c] = cfg[BIT_TRAP_PM];
            end else if (c == int'(CAT_PMC)) begin : g_pmc
                assign cat_en[c] = cfg[BIT_TRAP_PMC];
            end else if (c == int'(CAT_EXC)) begin : g_exc
                assign cat_en[c] = exc_eff;
            end else begin : g_none
                assign cat_en[c] = 1'b0;
            end
        end
    endgenerate

    // Level qualification: register accesses from EL0/EL1 only; exceptions at any level.
    always_comb begin
        lower_lvl = (req_lvl == LVL_0) || (req_lvl == LVL_1);
        is_exc    = (req_cat == CAT_EXC);
        trap      = req_valid && req_ns && cat_en[req_cat] && (is_exc || lower_lvl);
    end
endmodule

// File: rtl/hyp_dbg_trap_ctrl.sv
// Module: top of the hypervisor debug trap control block. Joins the
// access gate, the configuration storage and the trap evaluator.
// Assumes: read data is valid only while a permitted read is strobed.
module hyp_dbg_trap_ctrl
    import hdt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int IMPL_W    = 12,
    parameter int PMN_RESET = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_wr_en,
    input  logic              sr_rd_en,
    input  logic [1:0]        sr_el,
    input  logic              sr_ns,
    input  logic [DATA_W-1:0] sr_wdata,
    output logic [DATA_W-1:0] sr_rdata,
    output logic              sr_undef,
    input  logic              req_valid,
    input  logic [1:0]        req_el,
    input  logic              req_ns,
    input  logic [CAT_W-1:0]  req_cat,
    input  logic              guest_trap,
    output logic              trap
);
    localparam logic [31:0] RST_VAL = 32'(PMN_RESET);

    logic              wr_ok;
    logic              rd_ok;
    logic [DATA_W-1:0] cfg_q;

    hdt_access_gate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sr_wr_en),
        .rd_en   (sr_rd_en),
        .lvl     (sr_el),
        .ns      (sr_ns),
        .wr_ok   (wr_ok),
        .rd_ok   (rd_ok),
        .undef_q (sr_undef)
    );

    hdt_cfg_reg #(
        .DATA_W  (DATA_W),
        .IMPL_W  (IMPL_W),
        .RST_VAL (RST_VAL)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ok (wr_ok),
        .wdata (sr_wdata[IMPL_W-1:0]),
        .cfg_q (cfg_q)
    );

    hdt_trap_eval #(
        .DATA_W (DATA_W)
    ) u_eval (
        .cfg        (cfg_q),
        .guest_trap (guest_trap),
        .req_valid  (req_valid),
        .req_lvl    (req_el),
        .req_ns     (req_ns),
        .req_cat    (req_cat),
        .trap       (trap)
    );

    // Read mux: stored bits on a permitted read, zero otherwise.
    assign sr_rdata = rd_ok ? cfg_q : '0;
endmodule

// File: rtl/hdt_checker.sv
// Module: assertion checker bound to the top; observes ports and the stored word.
// Assumes: default DATA_W and IMPL_W of the top.
module hdt_checker #(
    parameter int DATA_W = 32,
    parameter int IMPL_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sr_wr_en,
    input logic              sr_rd_en,
    input logic [1:0]        sr_el,
    input logic              sr_ns,
    input logic [DATA_W-1:0] sr_wdata,
    input logic [DATA_W-1:0] sr_rdata,
    input logic              sr_undef,
    input logic              req_valid,
    input logic [1:0]        req_el,
    input logic              req_ns,
    input logic [2:0]        req_cat,
    input logic              guest_trap,
    input logic              trap,
    input logic [DATA_W-1:0] cfg_q
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'((64'd1 << IMPL_W) - 64'd1);

    logic allowed;
    logic dbg_lower;
    assign allowed   = (sr_el == 2'd2) || ((sr_el == 2'd3) && sr_ns);
    assign dbg_lower = req_valid && req_ns && (req_el < 2'd2) && (req_cat < 3'd3);

    p_undef_after_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((sr_wr_en || sr_rd_en) && !allowed) |=> sr_undef);
    p_undef_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !((sr_wr_en || sr_rd_en) && !allowed) |=> !sr_undef);
    p_refused_write_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && !allowed) |=> $stable(cfg_q));
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_en && allowed) |=> (cfg_q == ($past(sr_wdata) & KEEP)));
    p_read_hidden_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_rd_en && allowed) |-> (sr_rdata == '0));
    p_secure_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || !req_ns) |-> !trap);
    p_unused_cat_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_cat >= 3'd6) |-> !trap);
    p_exc_bit_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_lower && cfg_q[8]) |-> trap);
    p_guest_forces_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_lower && guest_trap) |-> trap);
endmodule

bind hyp_dbg_trap_ctrl hdt_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sr_wr_en   (sr_wr_en),
    .sr_rd_en   (sr_rd_en),
    .sr_el      (sr_el),
    .sr_ns      (sr_ns),
    .sr_wdata   (sr_wdata),
    .sr_rdata   (sr_rdata),
    .sr_undef   (sr_undef),
    .req_valid  (req_valid),
    .req_el     (req_el),
    .req_ns     (req_ns),
    .req_cat    (req_cat),
    .guest_trap (guest_trap),
    .trap       (trap),
    .cfg_q      (cfg_q)
);

// File: tb/hyp_dbg_trap_ctrl_tb_top.sv
// Bench: behavioural reference model compared against the block every cycle.
module hyp_dbg_trap_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RAND_STEPS = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_wr_en = 1'b0, sr_rd_en = 1'b0, sr_ns = 1'b0;
    logic [1:0]  sr_el = 2'd0;
    logic [31:0] sr_wdata = '0;
    logic [31:0] sr_rdata;
    logic        sr_undef;
    logic        req_valid = 1'b0, req_ns = 1'b0, guest_trap = 1'b0;
    logic [1:0]  req_el = 2'd0;
    logic [2:0]  req_cat = 3'd0;
    logic        trap;

    int checks = 0;
    int fails  = 0;

    bit [31:0] m_reg;
    bit        m_undef;

    always #(CLK_PERIOD/2) clk = ~clk;

    hyp_dbg_trap_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .sr_wr_en(sr_wr_en), .sr_rd_en(sr_rd_en), .sr_el(sr_el), .sr_ns(sr_ns),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .sr_undef(sr_undef),
        .req_valid(req_valid), .req_el(req_el), .req_ns(req_ns), .req_cat(req_cat),
        .guest_trap(guest_trap), .trap(trap)
    );

    function automatic bit allowed_m(input bit [1:0] el, input bit ns);
        return (el == 2) || (el == 3 && ns);
    endfunction

    function automatic bit trap_m(input bit v, input bit [1:0] el, input bit ns,
                                  input bit [2:0] cat, input bit g, input bit [31:0] r);
        bit x;
        x = r[8] | g;
        if (!v || !ns) return 0;
        if (cat == 5) return x;
        if (el >= 2) return 0;
        case (cat)
            0: return r[11] | x;
            1: return r[10] | x;
            2: return r[9] | x;
            3: return r[6];
            4: return r[5];
            default: return 0;
        endcase
    endfunction

    function automatic string trap_tag(input bit v, input bit [1:0] el, input bit ns,
                                       input bit [2:0] cat, input bit g, input bit [31:0] r);
        if (!v || !ns || (el >= 2 && cat != 5)) return "R6";
        if (cat >= 6) return "R11";
        if (cat == 5) return "R9";
        if (g) return "R8";
        if (r[8]) return "R7";
        return "R5";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: drive at negedge, compare, then advance the model at posedge.
    task automatic step(input bit wr, input bit rd, input bit [1:0] sel, input bit sns,
                        input bit [31:0] wd, input bit v, input bit [1:0] rel,
                        input bit rns, input bit [2:0] cat, input bit g, input string rtag);
        bit ok;
        @(negedge clk);
        sr_wr_en = wr; sr_rd_en = rd; sr_el = sel; sr_ns = sns; sr_wdata = wd;
        req_valid = v; req_el = rel; req_ns = rns; req_cat = cat; guest_trap = g;
        #1;
        ok = allowed_m(sel, sns);
        chk(rtag, sr_rdata, (rd && ok) ? m_reg : 32'h0);
        chk("R4", {31'h0, sr_undef}, {31'h0, m_undef});
        chk(trap_tag(v, rel, rns, cat, g, m_reg), {31'h0, trap},
            {31'h0, trap_m(v, rel, rns, cat, g, m_reg)});
        @(posedge clk);
        m_undef = (wr || rd) && !ok;
        if (wr && ok) m_reg = wd & 32'h0000_0FFF;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        m_reg = 32'h6; m_undef = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1: reset value read from EL2
        step(0, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R1");
        // R3: all-ones write from EL3 non-secure, upper bits dropped
        step(1, 0, 3, 1, 32'hFFFF_FFFF, 1, 0, 1, 0, 0, "R3");
        step(0, 1, 2, 1, 0, 1, 1, 1, 3, 0, "R3");
        // R4: refused writes from EL1 and secure EL3 keep the word
        step(1, 0, 1, 1, 32'h0, 0, 0, 0, 0, 0, "R4");
        step(1, 1, 3, 0, 32'h0, 0, 0, 0, 0, 0, "R2");
        step(0, 1, 2, 0, 0, 0, 0, 0, 0, 0, "R4");
        // R7: only bit 8 stored, debug categories trap; PM categories do not
        step(1, 0, 2, 0, 32'h100, 0, 0, 0, 0, 0, "R3");
        for (int c = 0; c < 8; c++) step(0, 1, 2, 0, 0, 1, 1, 1, 3'(c), 0, "R10");
        // R8: clear word, guest flag forces debug categories and exceptions
        step(1, 0, 2, 0, 32'h0, 0, 0, 0, 0, 0, "R3");
        for (int c = 0; c < 8; c++) step(0, 1, 2, 0, 0, 1, 0, 1, 3'(c), 1, "R10");
        // R10: bit 7 and partition field stored but inert
        step(1, 0, 2, 0, 32'h0000_009F, 0, 0, 0, 0, 0, "R3");
        for (int c = 0; c < 8; c++) step(0, 1, 2, 0, 0, 1, 0, 1, 3'(c), 0, "R10");
        // R5: individual trap bits
        step(1, 0, 2, 0, 32'h0000_0E60, 0, 0, 0, 0, 0, "R3");
        for (int c = 0; c < 8; c++) step(0, 1, 3, 1, 0, 1, 1, 1, 3'(c), 0, "R5");
        // R6: same requests from EL2 and secure
        for (int c = 0; c < 5; c++) step(0, 0, 0, 0, 0, 1, 2, 1, 3'(c), 0, "R6");
        for (int c = 0; c < 5; c++) step(0, 0, 0, 0, 0, 1, 0, 0, 3'(c), 1, "R6");
        // Random phase over all combinations
        for (int i = 0; i < RAND_STEPS; i++) begin
            step(($urandom % 4) == 0, ($urandom % 2) == 0, 2'($urandom), 1'($urandom),
                 $urandom, 1'($urandom), 2'($urandom), 1'($urandom), 3'($urandom),
                 ($urandom % 4) == 0, "R2");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule